// File: doc/BRIEF.md
# Automatic Reference and Mode Controller

This block is the control state machine of a two-reference digital clock synchroniser. It decides which of three operating modes the loop runs in: Normal (tracking a reference), Holdover (output held at a frequency value learned earlier) or Freerun (output taken from the local master clock only). In Normal mode it also picks which reference, primary or secondary, the loop tracks. In automatic control the decision comes only from two loss-of-signal inputs and a guard-time input, so no processor is needed. A two-bit control selector can bypass the automatic choice so that mode and reference follow external pins directly.

The block also raises a locked flag once the loop has stayed in Normal mode on one reference for a qualification time. The length of that time depends on the nominal reference frequency code. A store-enable qualifier follows the locked flag and tells the holdover memory when a frequency value may be captured. Every control input passes through a two-flop synchroniser before it is used. The phase detector, the loop filter, the oscillator and the output dividers sit outside this block.

Top module: `clk_ref_mode_ctrl`

## Requirements
- R1: While reset is asserted, and after reset until an input qualifies a reference, mode_o is Freerun (2'b10), ref_sec_o is 0 (primary), and locked_o and store_en_o are 0.
- R2: In automatic control, Freerun moves to Normal on the primary reference when los_pri is low. If los_pri is high and los_sec is low, it moves to Normal on the secondary reference. With both losses high it stays in Freerun and never goes to Holdover. Mode codes are Normal 2'b00, Holdover 2'b01 and Freerun 2'b10. ref_sec_o is 1 for the secondary reference.
- R3: In Normal mode, a loss on the active reference moves the block to Holdover and keeps the reference selection. This happens when guard is low, or when the other reference is also lost.
- R4: In Normal mode with guard high, a loss on the active reference while the other reference is clean switches straight to Normal on the other reference.
- R5: Holdover is left only when guard is high and at least one reference is clean. The primary reference is preferred. Otherwise Holdover holds.
- R6: In Normal mode, a loss on the inactive reference changes neither the mode, the reference nor the locked flag.
- R7: locked_o rises exactly N clock edges after the edge that enters Normal on a reference. N is LOCK_8K for freq_sel 2'b00 and 2'b11, LOCK_T1 for 2'b01 and LOCK_E1 for 2'b10. locked_o drops on the same edge that leaves Normal or changes the reference.
- R8: store_en_o is high only while locked_o is high in Normal mode.
- R9: When ctrl_sel is not 2'b00, mode_o follows man_mode and ref_sec_o follows man_ref. man_mode code 2'b11 gives Freerun. The loss and guard inputs have no effect.
- R10: A change on any control input reaches the outputs on the third rising clock edge after it is applied.
- R11: When ctrl_sel returns to 2'b00, automatic control continues from the mode and reference last set by the manual pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_sel | input | 2 | 2'b00 automatic control, any other value manual control |
| man_mode | input | 2 | Manual mode code |
| man_ref | input | 1 | Manual reference select, 1 = secondary |
| los_pri | input | 1 | Primary reference loss of signal |
| los_sec | input | 1 | Secondary reference loss of signal |
| guard | input | 1 | Guard time elapsed, permits reference switch or holdover exit |
| freq_sel | input | 2 | Nominal reference frequency code |
| mode_o | output | 2 | Active operating mode |
| ref_sec_o | output | 1 | Active reference, 1 = secondary |
| locked_o | output | 1 | Lock qualification complete in Normal mode |
| store_en_o | output | 1 | Holdover memory store qualifier |

## Verification
The hardest cases to reach are the Holdover cases that involve both references. One is the block staying in Holdover with guard high while both losses are set. The other is the primary reference winning when both references recover on the same cycle. The stimulus reaches them in steps. It first enters Normal on the primary reference with guard already high. It then drops the primary so the block moves to the secondary. It then drops the secondary so the block falls into Holdover with no clean reference. Finally it clears both losses together. The lock-timing checks count edges from the known entry edge, which is the third edge after the stimulus.

// File: rtl/ref_ctrl_pkg.sv
package ref_ctrl_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_HOLD   = 2'b01,
    MODE_FREE   = 2'b10
  } mode_e;

  typedef struct packed {
    mode_e mode;
    logic  ref_sec;
  } sel_t;

  localparam sel_t SEL_RESET = '{mode: MODE_FREE, ref_sec: 1'b0};
endpackage

// File: rtl/ref_sync.sv
module ref_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/ref_auto_fsm.sv
module ref_auto_fsm
  import ref_ctrl_pkg::*;
(
  input  sel_t cur,
  input  logic los_pri,
  input  logic los_sec,
  input  logic guard,
  output sel_t nxt
);
  logic los_act, los_oth;

  always_comb begin
    los_act = cur.ref_sec ? los_sec : los_pri;
    los_oth = cur.ref_sec ? los_pri : los_sec;
    nxt     = cur;
    unique case (cur.mode)
      MODE_FREE: begin
        if (!los_pri)      nxt = '{mode: MODE_NORMAL, ref_sec: 1'b0};
        else if (!los_sec) nxt = '{mode: MODE_NORMAL, ref_sec: 1'b1};
      end
      MODE_NORMAL: begin
        if (los_act) begin
          if (guard && !los_oth) nxt.ref_sec = !cur.ref_sec;
          else                   nxt.mode    = MODE_HOLD;
        end
      end
      MODE_HOLD: begin
        if (guard) begin
          if (!los_pri)      nxt = '{mode: MODE_NORMAL, ref_sec: 1'b0};
          else if (!los_sec) nxt = '{mode: MODE_NORMAL, ref_sec: 1'b1};
        end
      end
      default: nxt = SEL_RESET;
    endcase
  end
endmodule

// File: rtl/ref_lock_qual.sv
module ref_lock_qual #(
  parameter int LOCK_8K = 40,
  parameter int LOCK_T1 = 24,
  parameter int LOCK_E1 = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_normal,
  input  logic       restart,
  input  logic [1:0] freq_code,
  output logic       locked
);
  localparam int MAX_A = (LOCK_8K > LOCK_T1) ? LOCK_8K : LOCK_T1;
  localparam int MAX_L = (MAX_A > LOCK_E1) ? MAX_A : LOCK_E1;
  localparam int CW    = $clog2(MAX_L + 1);

  logic [CW-1:0] cnt_q, cnt_d, limit;
  logic          cnt_en;

  always_comb begin
    unique case (freq_code)
      2'b01:   limit = CW'(LOCK_T1);
      2'b10:   limit = CW'(LOCK_E1);
      default: limit = CW'(LOCK_8K);
    endcase
  end

  always_comb begin
    cnt_en = restart || (cnt_q < limit);
    cnt_d  = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign locked = in_normal && (cnt_q >= limit);
endmodule

// File: rtl/clk_ref_mode_ctrl.sv
module clk_ref_mode_ctrl
  import ref_ctrl_pkg::*;
#(
  parameter int LOCK_8K = 40,
  parameter int LOCK_T1 = 24,
  parameter int LOCK_E1 = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ctrl_sel,
  input  logic [1:0] man_mode,
  input  logic       man_ref,
  input  logic       los_pri,
  input  logic       los_sec,
  input  logic       guard,
  input  logic [1:0] freq_sel,
  output logic [1:0] mode_o,
  output logic       ref_sec_o,
  output logic       locked_o,
  output logic       store_en_o
);
  localparam int SW = 10;
  localparam logic [SW-1:0] SYNC_RST = 10'b00_00_0_00_0_11;

  logic rst_meta, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  logic [SW-1:0] raw_bus, sync_bus;
  logic [1:0]    ctrl_s, man_mode_s, freq_s;
  logic          man_ref_s, guard_s, los_sec_s, los_pri_s, auto_s;

  assign raw_bus = {ctrl_sel, man_mode, man_ref, freq_sel, guard, los_sec, los_pri};

  ref_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst_n (rst_i),
    .d   (raw_bus),
    .q   (sync_bus)
  );

  assign {ctrl_s, man_mode_s, man_ref_s, freq_s, guard_s, los_sec_s, los_pri_s} = sync_bus;
  assign auto_s = (ctrl_s == 2'b00);

  sel_t state_q, state_d, auto_nxt, man_sel;

  ref_auto_fsm u_fsm (
    .cur     (state_q),
    .los_pri (los_pri_s),
    .los_sec (los_sec_s),
    .guard   (guard_s),
    .nxt     (auto_nxt)
  );

  always_comb begin
    man_sel.mode    = (man_mode_s == 2'b11) ? MODE_FREE : mode_e'(man_mode_s);
    man_sel.ref_sec = man_ref_s;
    state_d         = auto_s ? auto_nxt : man_sel;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) state_q <= SEL_RESET;
    else        state_q <= state_d;
  end

  logic in_normal, restart;
  assign in_normal = (state_q.mode == MODE_NORMAL);
  assign restart   = !in_normal || (state_d != state_q);

  ref_lock_qual #(
    .LOCK_8K (LOCK_8K),
    .LOCK_T1 (LOCK_T1),
    .LOCK_E1 (LOCK_E1)
  ) u_lock (
    .clk       (clk),
    .rst_n     (rst_i),
    .in_normal (in_normal),
    .restart   (restart),
    .freq_code (freq_s),
    .locked    (locked_o)
  );

  assign mode_o     = state_q.mode;
  assign ref_sec_o  = state_q.ref_sec;
  assign store_en_o = locked_o && in_normal;
endmodule

// File: rtl/ref_ctrl_chk.sv
module ref_ctrl_chk
  import ref_ctrl_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_o,
  input logic       ref_sec_o,
  input logic       locked_o,
  input logic       store_en_o,
  input logic       auto_s,
  input logic       guard_s
);
  // R2: automatic control never goes from Freerun straight to Holdover
  a_r2_free_not_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_o) == MODE_FREE && $past(auto_s)) |-> mode_o != MODE_HOLD);

  // R4: a reference switch inside Normal mode needs guard
  a_r4_switch_guard: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_o) == MODE_NORMAL && mode_o == MODE_NORMAL &&
     !$stable(ref_sec_o) && $past(auto_s)) |-> $past(guard_s));

  // R5: leaving Holdover for Normal needs guard
  a_r5_hold_exit_guard: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_o) == MODE_HOLD && mode_o == MODE_NORMAL && $past(auto_s))
      |-> $past(guard_s));

  // R7: locked only in Normal mode
  a_r7_lock_normal: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> mode_o == MODE_NORMAL);

  // R7: lock never rises on the edge that changes mode or reference
  a_r7_lock_rise_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> ($stable(mode_o) && $stable(ref_sec_o)));

  // R7: a reference change clears lock
  a_r7_ref_change_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_sec_o) |-> !locked_o);

  // R8: store enable only while locked in Normal mode
  a_r8_store_locked: assert property (@(posedge clk) disable iff (!rst_n)
    store_en_o |-> (locked_o && mode_o == MODE_NORMAL));
endmodule

bind clk_ref_mode_ctrl ref_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_o     (mode_o),
  .ref_sec_o  (ref_sec_o),
  .locked_o   (locked_o),
  .store_en_o (store_en_o),
  .auto_s     (auto_s),
  .guard_s    (guard_s)
);

// File: tb/clk_ref_mode_ctrl_tb.sv
module clk_ref_mode_ctrl_tb;
  localparam int L8K = 40;
  localparam int LT1 = 24;
  localparam int LE1 = 16;
  localparam logic [1:0] M_NOR = 2'b00, M_HLD = 2'b01, M_FRE = 2'b10;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] ctrl_sel, man_mode, freq_sel, mode_o;
  logic man_ref, los_pri, los_sec, guard, ref_sec_o, locked_o, store_en_o;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = !clk;

  clk_ref_mode_ctrl #(.LOCK_8K(L8K), .LOCK_T1(LT1), .LOCK_E1(LE1)) u_dut (
    .clk (clk), .rst_n (rst_n), .ctrl_sel (ctrl_sel), .man_mode (man_mode),
    .man_ref (man_ref), .los_pri (los_pri), .los_sec (los_sec), .guard (guard),
    .freq_sel (freq_sel), .mode_o (mode_o), .ref_sec_o (ref_sec_o),
    .locked_o (locked_o), .store_en_o (store_en_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_state(input string req, input logic [1:0] m, input logic r);
    chk({req, " mode"}, int'(mode_o), int'(m));
    chk({req, " ref"}, int'(ref_sec_o), int'(r));
  endtask

  task automatic do_reset(input logic g, input logic [1:0] fs);
    @(negedge clk);
    rst_n = 1'b0; ctrl_sel = 2'b00; man_mode = 2'b00; man_ref = 1'b0;
    los_pri = 1'b1; los_sec = 1'b1; guard = g; freq_sel = fs;
    adv(2);
    rst_n = 1'b1;
    adv(5);
  endtask

  // R7/R8: sample point is directly after the Normal entry edge
  task automatic chk_lock(input string req, input int len);
    chk({req, " unlocked at entry"}, int'(locked_o), 0);
    adv(len - 1);
    chk({req, " unlocked at N-1"}, int'(locked_o), 0);
    adv(1);
    chk({req, " locked at N"}, int'(locked_o), 1);
    chk("R8 store follows lock", int'(store_en_o), 1);
  endtask

  task automatic t_reset_and_freerun();
    @(negedge clk);
    rst_n = 1'b0; ctrl_sel = 2'b00; man_mode = 2'b00; man_ref = 1'b0;
    los_pri = 1'b1; los_sec = 1'b1; guard = 1'b0; freq_sel = 2'b00;
    adv(2);
    chk_state("R1 in reset", M_FRE, 1'b0);
    chk("R1 locked in reset", int'(locked_o), 0);
    chk("R1 store in reset", int'(store_en_o), 0);
    rst_n = 1'b1;
    adv(8);
    chk_state("R2 both lost stays freerun", M_FRE, 1'b0);
    los_sec = 1'b0;
    adv(2);
    chk_state("R10 no change before third edge", M_FRE, 1'b0);
    adv(1);
    chk_state("R2 R10 secondary chosen", M_NOR, 1'b1);
  endtask

  task automatic t_hold_guard_low();
    do_reset(1'b0, 2'b01);
    los_pri = 1'b0;
    adv(3);
    chk_state("R2 primary chosen", M_NOR, 1'b0);
    chk_lock("R7 code01", LT1);
    los_sec = 1'b1;
    adv(3);
    chk_state("R6 inactive loss ignored", M_NOR, 1'b0);
    chk("R6 lock kept", int'(locked_o), 1);
    los_pri = 1'b1;
    adv(3);
    chk_state("R3 holdover on loss", M_HLD, 1'b0);
    chk("R7 lock drops in holdover", int'(locked_o), 0);
    chk("R8 store off in holdover", int'(store_en_o), 0);
    los_pri = 1'b0;
    adv(5);
    chk_state("R5 holdover waits for guard", M_HLD, 1'b0);
    guard = 1'b1;
    adv(3);
    chk_state("R5 holdover exit", M_NOR, 1'b0);
  endtask

  task automatic t_switch_and_both_lost();
    do_reset(1'b1, 2'b00);
    los_pri = 1'b0; los_sec = 1'b0;
    adv(3);
    chk_state("R2 primary preferred", M_NOR, 1'b0);
    chk_lock("R7 code00", L8K);
    los_pri = 1'b1;
    adv(3);
    chk_state("R4 direct switch", M_NOR, 1'b1);
    chk("R7 lock drops on switch", int'(locked_o), 0);
    los_sec = 1'b1;
    adv(3);
    chk_state("R3 both lost to holdover", M_HLD, 1'b1);
    adv(6);
    chk_state("R5 both lost holds", M_HLD, 1'b1);
    los_pri = 1'b0; los_sec = 1'b0;
    adv(3);
    chk_state("R5 primary preferred on exit", M_NOR, 1'b0);
  endtask

  task automatic t_manual();
    do_reset(1'b0, 2'b10);
    ctrl_sel = 2'b01; man_mode = 2'b01; man_ref = 1'b1;
    adv(3);
    chk_state("R9 manual holdover", M_HLD, 1'b1);
    los_pri = 1'b0; guard = 1'b1;
    adv(4);
    chk_state("R9 losses ignored", M_HLD, 1'b1);
    man_mode = 2'b11;
    adv(3);
    chk_state("R9 code 11 freerun", M_FRE, 1'b1);
    man_mode = 2'b00;
    adv(3);
    chk_state("R9 manual normal", M_NOR, 1'b1);
    chk_lock("R7 code10", LE1);
    los_pri = 1'b1; los_sec = 1'b0; ctrl_sel = 2'b00;
    adv(3);
    chk_state("R11 auto resumes", M_NOR, 1'b1);
    chk("R11 lock kept", int'(locked_o), 1);
  endtask

  initial begin
    t_reset_and_freerun();
    t_hold_guard_low();
    t_switch_and_both_lost();
    t_manual();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #3_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule